// File: doc/BRIEF.md
# Complete-Packet Transmit Gate

This block sits on the read side of a transmit FIFO that feeds a 10G MAC. It keeps the MAC from underrunning: a frame is let out of the FIFO only once its final word has been stored. To do this it counts whole packets. It watches end-of-packet handshakes on the FIFO write side and end-of-frame transfers on the read side. While no whole packet is stored, or while the MAC reports that it is full, the gate is closed. When the gate is closed, the FIFO read ready is held low and the valid and start-of-frame strobes toward the MAC are masked.

An optional cut-through mode is set by the parameter `CUT_LIMIT`, where zero turns it off. In this mode a latch opens the gate as soon as FIFO occupancy rises above `CUT_LIMIT` words, whether or not the frame is complete. The latch holds until an end-of-frame word is actually sent to the MAC. The FIFO address width is derived from the same parameter: `$clog2(CUT_LIMIT)+1` address bits when cut-through is on, and 10 when it is off. The occupancy input and the packet counter are each one bit wider than the address, so the counter cannot wrap even if every stored word ends a packet. The FIFO storage itself lives outside the block.

Top module: `pkt_tx_gate`

## Requirements
- R1: After a synchronous reset, with occupancy not above the threshold, `fifo_ready`, `mac_valid` and `mac_sof` are all low.
- R2: A write-side word with `wr_valid`, `wr_ready` and `wr_last` all high adds one stored packet, and the gate is open from the next cycle. A write without `wr_last` does not open the gate.
- R3: A read-side transfer (`fifo_valid` and `fifo_ready` high) with `fifo_last` high removes one stored packet. When the last stored packet leaves, the gate closes in the next cycle.
- R4: An end-of-packet write and an end-of-frame read in the same cycle leave the stored packet count unchanged.
- R5: While the gate is closed, `fifo_ready`, `mac_valid` and `mac_sof` are low whatever `fifo_valid` and `fifo_sof` are.
- R6: With the cut-through latch clear, `mac_full` high closes the gate in the same cycle, even when whole packets are stored.
- R7: The cut-through latch sets on the cycle after `fifo_occ` is strictly greater than `CUT_LIMIT`. Occupancy equal to the threshold does not set it.
- R8: Once set, the latch keeps the gate open until a word with `mac_valid` and `fifo_last` high has been sent. It is clear from the next cycle.
- R9: If occupancy is above the threshold in the same cycle that an end-of-frame word is sent, the latch stays set.
- R10: While the gate is open, `fifo_ready` is high, `mac_valid` equals `fifo_valid` and `mac_sof` equals `fifo_sof`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the MAC side |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | FIFO write-side valid (observed) |
| wr_ready | input | 1 | FIFO write-side ready (observed) |
| wr_last | input | 1 | FIFO write-side end of packet (observed) |
| fifo_occ | input | OCC_W | Words currently held in the FIFO |
| fifo_valid | input | 1 | FIFO read-side valid |
| fifo_sof | input | 1 | Start of frame flag of the FIFO head word |
| fifo_last | input | 1 | End of frame flag of the FIFO head word |
| fifo_ready | output | 1 | Read enable to the FIFO, gated |
| mac_full | input | 1 | MAC transmit buffer full |
| mac_valid | output | 1 | Valid toward the MAC, gated |
| mac_sof | output | 1 | Start of frame toward the MAC, gated |

## Verification
The bench targets the following corner cases, and each one names the fault it would expose:
- An end-of-packet write and read in the same cycle. A counter that lets one side win would either open the gate on an empty FIFO or stall forever with a frame inside.
- Occupancy exactly at the threshold versus one above it. Using a non-strict compare would start frames one word early.
- A threshold crossing in the same cycle as an end of frame. A latch where clear wins would drop out of cut-through with a partly stored frame at the head.
- Head words that end a frame offered while the gate is closed. If these were counted as sent, the packet count would drift.
- Random traffic with MAC backpressure, compared against a reference model in the bench.

// File: rtl/pkt_tx_gate_pkg.sv
package pkt_tx_gate_pkg;

   // FIFO address bits implied by the cut-through threshold (0 = off)
   function automatic int gate_addr_bits(input int limit);
      return (limit > 0) ? $clog2(limit) + 1 : 10;
   endfunction

endpackage

// File: rtl/pkt_tx_gate_count.sv
module pkt_tx_gate_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             has_pkt
);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   cnt <= cnt + CNT_W'(1);
            2'b01:   cnt <= cnt - CNT_W'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   assign has_pkt = (cnt != '0);

endmodule

// File: rtl/pkt_tx_gate_cut.sv
module pkt_tx_gate_cut #(
   parameter int OCC_W = 8,
   parameter int LIMIT = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OCC_W-1:0] occ,
   input  logic             eof_sent,
   output logic             cut_on
);

   generate
      if (LIMIT > 0) begin : g_cut
         logic over;
         logic lat_q;
         assign over = (occ > OCC_W'(LIMIT));
         always_ff @(posedge clk) begin
            if (rst)           lat_q <= 1'b0;
            else if (over)     lat_q <= 1'b1;
            else if (eof_sent) lat_q <= 1'b0;
         end
         assign cut_on = lat_q;
      end else begin : g_store_fwd
         assign cut_on = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pkt_tx_gate.sv
module pkt_tx_gate #(
   parameter int CUT_LIMIT = 64,
   parameter int OCC_W     = pkt_tx_gate_pkg::gate_addr_bits(CUT_LIMIT) + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_valid,
   input  logic             wr_ready,
   input  logic             wr_last,
   input  logic [OCC_W-1:0] fifo_occ,
   input  logic             fifo_valid,
   input  logic             fifo_sof,
   input  logic             fifo_last,
   output logic             fifo_ready,
   input  logic             mac_full,
   output logic             mac_valid,
   output logic             mac_sof
);

   localparam int ADDR_W = pkt_tx_gate_pkg::gate_addr_bits(CUT_LIMIT);
   localparam int CNT_W  = ADDR_W + 1;

   generate
      if (CUT_LIMIT < 0) begin : g_bad_limit
         $error("pkt_tx_gate: CUT_LIMIT must not be negative");
      end
      if (OCC_W != ADDR_W + 1) begin : g_bad_occ
         $error("pkt_tx_gate: OCC_W must be address bits plus one");
      end
   endgenerate

   logic             pkt_in;
   logic             pkt_out;
   logic [CNT_W-1:0] pkt_cnt;
   logic             has_pkt;
   logic             cut_on;
   logic             tx_en;
   logic             gate_open;

   assign pkt_in  = wr_valid & wr_ready & wr_last;
   assign pkt_out = fifo_valid & fifo_ready & fifo_last;

   pkt_tx_gate_count #(.CNT_W(CNT_W)) count_i (
      .clk     (clk),
      .rst     (rst),
      .inc     (pkt_in),
      .dec     (pkt_out),
      .cnt     (pkt_cnt),
      .has_pkt (has_pkt)
   );

   pkt_tx_gate_cut #(.OCC_W(OCC_W), .LIMIT(CUT_LIMIT)) cut_i (
      .clk      (clk),
      .rst      (rst),
      .occ      (fifo_occ),
      .eof_sent (mac_valid & fifo_last),
      .cut_on   (cut_on)
   );

   assign tx_en      = has_pkt & ~mac_full;
   assign gate_open  = tx_en | cut_on;
   assign fifo_ready = gate_open;
   assign mac_valid  = gate_open & fifo_valid;
   assign mac_sof    = gate_open & fifo_sof;

endmodule

// File: rtl/pkt_tx_gate_chk.sv
module pkt_tx_gate_chk #(
   parameter int OCC_W = 8,
   parameter int CNT_W = 8,
   parameter int LIMIT = 64
) (
   input logic             clk,
   input logic             rst,
   input logic             pkt_in,
   input logic             pkt_out,
   input logic [CNT_W-1:0] pkt_cnt,
   input logic             cut_on,
   input logic [OCC_W-1:0] fifo_occ,
   input logic             mac_full,
   input logic             fifo_ready,
   input logic             mac_valid,
   input logic             mac_sof
);

   assert_count_up_R2: assert property (@(posedge clk) disable iff (rst)
      (pkt_in && !pkt_out) |=> (pkt_cnt == $past(pkt_cnt) + CNT_W'(1)));

   assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
      (pkt_out && !pkt_in) |=> (pkt_cnt == $past(pkt_cnt) - CNT_W'(1)));

   assert_count_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (pkt_in && pkt_out) |=> $stable(pkt_cnt));

   assert_closed_masks_R5: assert property (@(posedge clk) disable iff (rst)
      (pkt_cnt == '0 && !cut_on) |-> (!fifo_ready && !mac_valid && !mac_sof));

   assert_full_blocks_R6: assert property (@(posedge clk) disable iff (rst)
      (mac_full && !cut_on) |-> (!fifo_ready && !mac_valid));

   generate
      if (LIMIT > 0) begin : g_cut_chk
         assert_cut_set_R7: assert property (@(posedge clk) disable iff (rst)
            (fifo_occ > OCC_W'(LIMIT)) |=> cut_on);
      end
   endgenerate

endmodule

bind pkt_tx_gate pkt_tx_gate_chk #(
   .OCC_W (OCC_W),
   .CNT_W (CNT_W),
   .LIMIT (CUT_LIMIT)
) chk_i (
   .clk        (clk),
   .rst        (rst),
   .pkt_in     (pkt_in),
   .pkt_out    (pkt_out),
   .pkt_cnt    (pkt_cnt),
   .cut_on     (cut_on),
   .fifo_occ   (fifo_occ),
   .mac_full   (mac_full),
   .fifo_ready (fifo_ready),
   .mac_valid  (mac_valid),
   .mac_sof    (mac_sof)
);

// File: tb/pkt_tx_gate_tb_top.sv
`timescale 1ns/1ps
module pkt_tx_gate_tb_top;

   localparam int LIM   = 8;
   localparam int OCC_W = $clog2(LIM) + 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic wr_valid = 0, wr_ready = 0, wr_last = 0;
   logic [OCC_W-1:0] fifo_occ = '0;
   logic fifo_valid = 0, fifo_sof = 0, fifo_last = 0;
   logic mac_full = 0;
   logic fifo_ready, mac_valid, mac_sof;

   int errors = 0;
   int checks = 0;
   int mcnt = 0;
   bit mlat = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pkt_tx_gate #(.CUT_LIMIT(LIM)) dut_i (
      .clk(clk), .rst(rst),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_last(wr_last),
      .fifo_occ(fifo_occ),
      .fifo_valid(fifo_valid), .fifo_sof(fifo_sof), .fifo_last(fifo_last),
      .fifo_ready(fifo_ready),
      .mac_full(mac_full),
      .mac_valid(mac_valid), .mac_sof(mac_sof)
   );

   function automatic bit exp_open(input int cnt, input bit lat, input bit full);
      return ((cnt != 0) && !full) || lat;
   endfunction

   // Drive-settled check of one cycle, then advance the model at the edge
   task automatic cyc(input string tag);
      bit op, ev, es;
      #2;
      op = exp_open(mcnt, mlat, mac_full);
      ev = op & fifo_valid;
      es = op & fifo_sof;
      checks++;
      if (fifo_ready !== op || mac_valid !== ev || mac_sof !== es) begin
         errors++;
         $display("FAIL %s: ready/valid/sof=%b%b%b expected %b%b%b (cnt=%0d lat=%0d)",
                  tag, fifo_ready, mac_valid, mac_sof, op, ev, es, mcnt, mlat);
      end
      @(posedge clk);
      if (rst) begin
         mcnt = 0; mlat = 0;
      end else begin
         mcnt = mcnt + int'(wr_valid & wr_ready & wr_last)
                     - int'(op & fifo_valid & fifo_last);
         if (int'(fifo_occ) > LIM)          mlat = 1;
         else if (op & fifo_valid & fifo_last) mlat = 0;
      end
      @(negedge clk);
   endtask

   task automatic idle();
      wr_valid = 0; wr_ready = 0; wr_last = 0;
      fifo_valid = 0; fifo_sof = 0; fifo_last = 0;
      fifo_occ = '0; mac_full = 0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 0;
      // R1: reset state, head word offered
      fifo_valid = 1; fifo_sof = 1;
      cyc("R1");
      // R5: nothing stored, gate stays closed
      fifo_last = 1;
      cyc("R5");
      // R2: write without last keeps closed, with last opens
      idle(); wr_valid = 1; wr_ready = 1;
      cyc("R2");
      cyc("R2");
      wr_last = 1;
      cyc("R2");
      idle(); fifo_valid = 1; fifo_sof = 1;
      cyc("R2");
      // R6: MAC full closes, release reopens
      mac_full = 1;
      cyc("R6");
      mac_full = 0;
      cyc("R10");
      // R3: last packet leaves, gate closes
      fifo_last = 1;
      cyc("R3");
      cyc("R3");
      // R4: write and read of end-of-packet in one cycle
      idle(); wr_valid = 1; wr_ready = 1; wr_last = 1;
      cyc("R2");
      fifo_valid = 1; fifo_last = 1;
      cyc("R4");
      idle(); fifo_valid = 1;
      cyc("R4");
      fifo_last = 1;
      cyc("R3");
      idle(); fifo_valid = 1;
      cyc("R3");
      // R7: equal to threshold does not latch, above does
      fifo_occ = OCC_W'(LIM);
      cyc("R7");
      cyc("R7");
      fifo_occ = OCC_W'(LIM + 1);
      cyc("R7");
      fifo_occ = '0;
      cyc("R7");
      // R8: hold until end of frame sent
      cyc("R8");
      fifo_valid = 0; fifo_last = 1;
      cyc("R8");
      fifo_valid = 1;
      cyc("R8");
      fifo_last = 0;
      cyc("R8");
      // R9: set wins over clear
      fifo_occ = OCC_W'(LIM + 3);
      cyc("R7");
      fifo_last = 1;
      cyc("R9");
      fifo_occ = '0; fifo_last = 0;
      cyc("R9");
      fifo_last = 1;
      cyc("R8");
      idle();
      cyc("R8");
      // Random traffic against the model
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 4000; i++) begin
         wr_valid   = $urandom_range(0, 1);
         wr_ready   = $urandom_range(0, 3) != 0;
         wr_last    = (mcnt < 15) && ($urandom_range(0, 2) == 0);
         fifo_valid = $urandom_range(0, 3) != 0;
         fifo_sof   = $urandom_range(0, 1);
         fifo_last  = (mcnt > 0) && ($urandom_range(0, 2) == 0);
         mac_full   = $urandom_range(0, 3) == 0;
         fifo_occ   = ($urandom_range(0, 5) == 0) ? OCC_W'($urandom_range(0, 12))
                                                  : OCC_W'($urandom_range(0, LIM));
         cyc(exp_open(mcnt, mlat, mac_full) ? "R10" : "R5");
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule